// File: doc/BRIEF.md
# Overlapped Priority Bus Arbiter

This block decides which of several masters owns a shared high-bandwidth on-chip bus. It has two independent arbitration channels, one for reads and one for writes, so one read and one write can proceed at once, each owned by its own master. Every master drives a request line per direction, plus a priority value, a transfer kind, a burst beat count, a burst-continue flag and a lock flag. The read and write channels share these attributes. The arbiter keeps a grant on one master per channel for the whole transfer and counts data acknowledges to find the final data cycle.

The choice of the next owner is made during that final data cycle. The new grant appears on the very next clock, so the bus never sits idle between owners. Among the requesters, the highest priority wins. Ties are broken in round-robin order, starting after the last owner. A master that holds its lock keeps the channel across back-to-back transfers. When no one is requesting, the grant stays parked on the last owner.

Each channel is a four-state machine:
- **ST_EMPTY**: no owner since reset. Goes to ST_BUSY on any request.
- **ST_PARK**: owner granted, no transfer. Goes to ST_BUSY on any request, after arbitration.
- **ST_BUSY**: transfer in progress. On the last beat it goes to one of three places:
  - ST_BUSY with a new or the same owner (overlap), when a request is pending;
  - ST_HOLD, when the owner is locked but not requesting;
  - ST_PARK, when nothing is pending.
- **ST_HOLD**: locked idle. Goes to ST_BUSY when the owner requests again. When the lock drops, it goes to ST_BUSY after arbitration, or to ST_PARK if nothing is pending.

Top module: `mm_bus_arbiter`

## Requirements
- R1: Each channel asserts at most one grant bit at a time. Both grant vectors are all zero after reset until the first request.
- R2: Priority is `PRIO_W` bits per master, with master i at bits [i*PRIO_W +: PRIO_W]. A larger value wins over all lower-valued pending requests.
- R3: When several requests share the highest priority, the winner is the first requester found searching upward from the last owner's index plus one, wrapping around. After reset the search starts at master 0.
- R4: When a transfer's last data acknowledge is sampled and another unlocked request is pending, the new grant is visible on the next clock, with no cycle between owners.
- R5: The transfer kind is 2 bits per master, at bits [i*2 +: 2]. The encodings are: 00 single, 01 fixed burst, 10 variable burst, 11 single. A single transfer ends on its first data acknowledge.
- R6: A fixed burst loads the 4-bit beat count at bits [i*4 +: 4] and decrements it on each data acknowledge. It ends on the acknowledge sampled while the count is 1. A count of 0 is taken as 1. The grant does not move mid-burst.
- R7: A variable burst ends on the first data acknowledge sampled while the owner's burst-continue bit is low.
- R8: While the owner's lock bit is high at the end of a transfer, and in every cycle afterwards until the lock drops, the grant stays on that owner. Higher-priority requests are ignored during this time.
- R9: With no request pending after a transfer ends, the grant stays on the last owner.
- R10: The read and write channels arbitrate independently. One master may hold both grants at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | NUM_M | Read request, one bit per master |
| wr_req | input | NUM_M | Write request, one bit per master |
| req_prio | input | NUM_M*PRIO_W | Priority value of each master |
| req_kind | input | NUM_M*2 | Transfer kind of each master |
| req_beats | input | NUM_M*4 | Fixed-burst beat count of each master |
| req_cont | input | NUM_M | Variable-burst continue flag of each master |
| req_lock | input | NUM_M | Lock flag of each master |
| rd_data_ack | input | 1 | Read data beat acknowledged |
| wr_data_ack | input | 1 | Write data beat acknowledged |
| rd_grant | output | NUM_M | One-hot read grant |
| wr_grant | output | NUM_M | One-hot write grant |

## Verification
The bench moves ownership directly between masters while acknowledges keep coming.

- **Arbitration a cycle late.** A design that decided the next owner one cycle late would show a grant gap, or the old owner for an extra beat.
- **Beat counting.** Fixed bursts of three beats and of zero beats catch off-by-one counting, which would release the bus one beat early or late.
- **Variable bursts.** A burst held open for several beats checks that the continue flag, not the beat count, ends it.
- **Equal priorities.** With all masters tied, a full rotation catches round-robin that restarts at master 0.
- **Lock.** A locked owner faces a higher-priority rival, both during back-to-back transfers and while idle in the hold state. A design that ignored the lock would hand the bus over.
- **Parking and concurrency.** The bench checks that the grant stays parked, and that one master can hold the read and write grants at the same time.

// File: rtl/arb_pkg.sv
package arb_pkg;
    localparam int KIND_W = 2;
    localparam int BEAT_W = 4;

    typedef enum logic [KIND_W-1:0] {
        KIND_SINGLE = 2'b00,
        KIND_FIXED  = 2'b01,
        KIND_VAR    = 2'b10,
        KIND_RSVD   = 2'b11
    } xfer_kind_e;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'b00,
        ST_PARK  = 2'b01,
        ST_BUSY  = 2'b10,
        ST_HOLD  = 2'b11
    } chan_state_e;
endpackage

// File: rtl/arb_pick.sv
module arb_pick #(
    parameter int NUM_M  = 4,
    parameter int PRIO_W = 2,
    parameter int IDX_W  = 2
) (
    input  logic [NUM_M-1:0]        req,
    input  logic [NUM_M*PRIO_W-1:0] prio,
    input  logic [IDX_W-1:0]        last_idx,
    output logic                    any_req,
    output logic [IDX_W-1:0]        win_idx
);
    logic [PRIO_W-1:0] top_prio;
    logic [NUM_M-1:0]  cand;

    // highest priority among pending requests
    always_comb begin
        top_prio = '0;
        for (int i = 0; i < NUM_M; i++) begin
            if (req[i] && (prio[i*PRIO_W +: PRIO_W] > top_prio))
                top_prio = prio[i*PRIO_W +: PRIO_W];
        end
    end

    genvar g;
    generate
        for (g = 0; g < NUM_M; g++) begin : g_cand
            assign cand[g] = req[g] && (prio[g*PRIO_W +: PRIO_W] == top_prio);
        end
    endgenerate

    assign any_req = |req;

    // round-robin search starting one past the last owner
    always_comb begin
        logic found;
        found   = 1'b0;
        win_idx = last_idx;
        for (int k = 1; k <= NUM_M; k++) begin
            int j;
            j = int'(last_idx) + k;
            if (j >= NUM_M) j = j - NUM_M;
            if (!found && cand[j]) begin
                win_idx = IDX_W'(j);
                found   = 1'b1;
            end
        end
    end
endmodule

// File: rtl/arb_channel.sv
module arb_channel
    import arb_pkg::*;
#(
    parameter int NUM_M  = 4,
    parameter int PRIO_W = 2,
    parameter int IDX_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_M-1:0]        req,
    input  logic [NUM_M*PRIO_W-1:0] prio,
    input  logic [NUM_M*KIND_W-1:0] kind,
    input  logic [NUM_M*BEAT_W-1:0] beats,
    input  logic [NUM_M-1:0]        cont,
    input  logic [NUM_M-1:0]        lock,
    input  logic                    data_ack,
    output logic [NUM_M-1:0]        grant
);
    chan_state_e       state_q, state_d;
    logic [IDX_W-1:0]  owner_q, owner_d;
    logic [BEAT_W-1:0] cnt_q, cnt_d;
    xfer_kind_e        kind_q, kind_d;

    logic             any_req;
    logic [IDX_W-1:0] win_idx;
    logic             own_lock, own_req, own_cont, last_beat;

    arb_pick #(
        .NUM_M (NUM_M),
        .PRIO_W(PRIO_W),
        .IDX_W (IDX_W)
    ) u_pick (
        .req     (req),
        .prio    (prio),
        .last_idx(owner_q),
        .any_req (any_req),
        .win_idx (win_idx)
    );

    assign own_lock = lock[owner_q];
    assign own_req  = req[owner_q];
    assign own_cont = cont[owner_q];

    always_comb begin
        last_beat = 1'b0;
        if (state_q == ST_BUSY && data_ack) begin
            unique case (kind_q)
                KIND_FIXED: last_beat = (cnt_q <= BEAT_W'(1));
                KIND_VAR:   last_beat = !own_cont;
                default:    last_beat = 1'b1;
            endcase
        end
    end

    // next-state logic
    always_comb begin
        logic             take, restart;
        logic [IDX_W-1:0] sel;
        logic [BEAT_W-1:0] ld_beats;
        take     = 1'b0;
        restart  = 1'b0;
        state_d  = state_q;
        owner_d  = owner_q;
        cnt_d    = cnt_q;
        kind_d   = kind_q;
        unique case (state_q)
            ST_EMPTY: if (any_req) take = 1'b1;
            ST_PARK:  if (any_req) take = 1'b1;
            ST_HOLD: begin
                if (!own_lock) begin
                    if (any_req) take = 1'b1;
                    else         state_d = ST_PARK;
                end else if (own_req) begin
                    restart = 1'b1;
                end
            end
            ST_BUSY: begin
                if (last_beat) begin
                    if (own_lock) begin
                        if (own_req) restart = 1'b1;
                        else         state_d = ST_HOLD;
                    end else if (any_req) begin
                        take = 1'b1;
                    end else begin
                        state_d = ST_PARK;
                    end
                end else if (data_ack && kind_q == KIND_FIXED) begin
                    cnt_d = cnt_q - BEAT_W'(1);
                end
            end
        endcase
        sel      = take ? win_idx : owner_q;
        ld_beats = beats[int'(sel)*BEAT_W +: BEAT_W];
        if (take || restart) begin
            state_d = ST_BUSY;
            owner_d = sel;
            kind_d  = xfer_kind_e'(kind[int'(sel)*KIND_W +: KIND_W]);
            cnt_d   = (ld_beats == '0) ? BEAT_W'(1) : ld_beats;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            owner_q <= IDX_W'(NUM_M - 1);
            cnt_q   <= '0;
            kind_q  <= KIND_SINGLE;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
            cnt_q   <= cnt_d;
            kind_q  <= kind_d;
        end
    end

    // outputs
    always_comb begin
        grant = '0;
        if (state_q != ST_EMPTY) grant[owner_q] = 1'b1;
    end

    assert_single_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    assert_winner_requests_R2: assert property (@(posedge clk) disable iff (!rst_n)
        any_req |-> req[win_idx]);

    assert_no_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY && last_beat && !own_lock && any_req)
            |=> (state_q == ST_BUSY && grant != '0));

    assert_mid_burst_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUSY && !last_beat) |=> $stable(grant));

    assert_lock_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_BUSY && last_beat && own_lock) ||
         (state_q == ST_HOLD && own_lock)) |=> $stable(grant));

    assert_park_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PARK && !any_req) |=> $stable(grant));
endmodule

// File: rtl/mm_bus_arbiter.sv
module mm_bus_arbiter
    import arb_pkg::*;
#(
    parameter int NUM_M  = 4,
    parameter int PRIO_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_M-1:0]        rd_req,
    input  logic [NUM_M-1:0]        wr_req,
    input  logic [NUM_M*PRIO_W-1:0] req_prio,
    input  logic [NUM_M*2-1:0]      req_kind,
    input  logic [NUM_M*4-1:0]      req_beats,
    input  logic [NUM_M-1:0]        req_cont,
    input  logic [NUM_M-1:0]        req_lock,
    input  logic                    rd_data_ack,
    input  logic                    wr_data_ack,
    output logic [NUM_M-1:0]        rd_grant,
    output logic [NUM_M-1:0]        wr_grant
);
    localparam int IDX_W  = (NUM_M > 1) ? $clog2(NUM_M) : 1;
    localparam int NUM_CH = 2;

    logic [NUM_CH-1:0][NUM_M-1:0] ch_req;
    logic [NUM_CH-1:0][NUM_M-1:0] ch_grant;
    logic [NUM_CH-1:0]            ch_ack;

    assign ch_req   = {wr_req, rd_req};
    assign ch_ack   = {wr_data_ack, rd_data_ack};
    assign rd_grant = ch_grant[0];
    assign wr_grant = ch_grant[1];

    genvar c;
    generate
        for (c = 0; c < NUM_CH; c++) begin : g_chan
            arb_channel #(
                .NUM_M (NUM_M),
                .PRIO_W(PRIO_W),
                .IDX_W (IDX_W)
            ) u_chan (
                .clk     (clk),
                .rst_n   (rst_n),
                .req     (ch_req[c]),
                .prio    (req_prio),
                .kind    (req_kind),
                .beats   (req_beats),
                .cont    (req_cont),
                .lock    (req_lock),
                .data_ack(ch_ack[c]),
                .grant   (ch_grant[c])
            );
        end
    endgenerate
endmodule

// File: tb/test_mm_bus_arbiter.sv
module test_mm_bus_arbiter;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] rd_req = '0, wr_req = '0;
    logic [N*2-1:0] req_prio = '0;
    logic [N*2-1:0] req_kind = '0;
    logic [N*4-1:0] req_beats = '0;
    logic [N-1:0] req_cont = '0, req_lock = '0;
    logic         rd_data_ack = 1'b0, wr_data_ack = 1'b0;
    logic [N-1:0] rd_grant, wr_grant;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mm_bus_arbiter #(.NUM_M(N), .PRIO_W(2)) i_mm_bus_arbiter (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req),
        .req_prio(req_prio), .req_kind(req_kind), .req_beats(req_beats),
        .req_cont(req_cont), .req_lock(req_lock),
        .rd_data_ack(rd_data_ack), .wr_data_ack(wr_data_ack),
        .rd_grant(rd_grant), .wr_grant(wr_grant)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic set_m(int i, int p, int k, int b);
        req_prio[i*2 +: 2]  = 2'(p);
        req_kind[i*2 +: 2]  = 2'(k);
        req_beats[i*4 +: 4] = 4'(b);
    endtask

    task automatic t_reset();
        chk("R1 reset rd", rd_grant, 4'b0000);
        chk("R1 reset wr", wr_grant, 4'b0000);
    endtask

    task automatic t_priority();
        set_m(1, 1, 0, 0); set_m(2, 3, 0, 0);
        rd_req = 4'b0110;
        tick(); chk("R2 high prio wins", rd_grant, 4'b0100);
        rd_data_ack = 1'b1; rd_req = 4'b0010;
        tick(); chk("R4 R5 handover after single", rd_grant, 4'b0010);
        rd_req = 4'b0000;
        tick(); rd_data_ack = 1'b0;
        tick(); chk("R9 parked on last owner", rd_grant, 4'b0010);
        tick(); chk("R9 still parked", rd_grant, 4'b0010);
    endtask

    task automatic t_round_robin();
        for (int i = 0; i < N; i++) set_m(i, 2, 0, 0);
        rd_req = 4'b1111;
        tick(); chk("R3 start after owner 1", rd_grant, 4'b0100);
        rd_data_ack = 1'b1;
        tick(); chk("R3 rotate to 3", rd_grant, 4'b1000);
        tick(); chk("R3 wrap to 0", rd_grant, 4'b0001);
        tick(); chk("R3 rotate to 1", rd_grant, 4'b0010);
        tick(); chk("R3 rotate to 2", rd_grant, 4'b0100);
        rd_req = 4'b0000;
        tick(); rd_data_ack = 1'b0;
        chk("R9 park after rotation", rd_grant, 4'b0100);
    endtask

    task automatic t_fixed();
        set_m(0, 3, 1, 3); set_m(3, 0, 0, 0);
        wr_req = 4'b1001;
        tick(); chk("R6 fixed owner", wr_grant, 4'b0001);
        wr_data_ack = 1'b1;
        tick(); chk("R6 beat 1 holds", wr_grant, 4'b0001);
        tick(); chk("R6 beat 2 holds", wr_grant, 4'b0001);
        wr_req = 4'b1000;
        tick(); chk("R6 R4 switch after beat 3", wr_grant, 4'b1000);
        wr_req = 4'b0000;
        tick(); wr_data_ack = 1'b0;
        set_m(1, 3, 1, 0); set_m(2, 1, 0, 0);
        wr_req = 4'b0110;
        tick(); chk("R6 zero count owner", wr_grant, 4'b0010);
        wr_data_ack = 1'b1; wr_req = 4'b0100;
        tick(); chk("R6 zero count ends in one beat", wr_grant, 4'b0100);
        wr_req = 4'b0000;
        tick(); wr_data_ack = 1'b0;
    endtask

    task automatic t_variable();
        set_m(3, 3, 2, 0); set_m(0, 1, 0, 0);
        req_cont[3] = 1'b1;
        rd_req = 4'b1001;
        tick(); chk("R7 variable owner", rd_grant, 4'b1000);
        rd_data_ack = 1'b1;
        for (int b = 0; b < 3; b++) begin
            tick(); chk("R7 continue holds", rd_grant, 4'b1000);
        end
        req_cont[3] = 1'b0; rd_req = 4'b0001;
        tick(); chk("R7 ends when continue low", rd_grant, 4'b0001);
        rd_req = 4'b0000;
        tick(); rd_data_ack = 1'b0;
    endtask

    task automatic t_lock();
        set_m(2, 0, 0, 0); set_m(1, 3, 0, 0);
        req_lock[2] = 1'b1;
        wr_req = 4'b0100;
        tick(); chk("R8 locker owns", wr_grant, 4'b0100);
        wr_req = 4'b0110; wr_data_ack = 1'b1;
        tick(); chk("R8 back-to-back locked", wr_grant, 4'b0100);
        wr_req = 4'b0010;
        tick(); chk("R8 hold after locked end", wr_grant, 4'b0100);
        wr_data_ack = 1'b0;
        tick(); chk("R8 hold ignores rival", wr_grant, 4'b0100);
        req_lock[2] = 1'b0;
        tick(); chk("R8 release hands over", wr_grant, 4'b0010);
        wr_data_ack = 1'b1; wr_req = 4'b0000;
        tick(); wr_data_ack = 1'b0;
    endtask

    task automatic t_concurrent();
        set_m(0, 0, 0, 0);
        rd_req = 4'b0001; wr_req = 4'b0001;
        tick();
        chk("R10 read grant", rd_grant, 4'b0001);
        chk("R10 write grant", wr_grant, 4'b0001);
        rd_data_ack = 1'b1; wr_data_ack = 1'b1;
        rd_req = 4'b0000; wr_req = 4'b0000;
        tick(); rd_data_ack = 1'b0; wr_data_ack = 1'b0;
        chk("R1 one read grant", rd_grant, 4'b0001);
    endtask

    initial begin
        tick(); tick();
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_priority();
        t_round_robin();
        t_fixed();
        t_variable();
        t_lock();
        t_concurrent();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule